// File: doc/BRIEF.md
# Microwire Serial EEPROM Host Controller

This block is the master side of a three-wire serial link to a 16-bit-word EEPROM with a 10-bit word address. A request port takes one of four operations: single-word read, sequential burst read, single-word write, or a write of one value to every location. For each operation the block drives chip select, serial clock and the serial data line toward the memory, and it returns read words and a completion result on a response port.

Every frame opens with a start bit and carries an opcode and an address. Write frames also carry sixteen data bits. Reads skip the single dummy bit that the memory returns and then gather data words. A burst keeps the frame open and collects one further word every sixteen clocks. A write is committed by dropping chip select after the last data bit has been clocked in and before any further clock rises. The block then reselects the device and watches the memory's ready/busy level until it reads ready or a timeout limit runs out.

The serial clock is made from the system clock. Each half period lasts `DIV` system cycles.

Top module: `mw_eeprom_host`

## Requirements
- R1: After reset, chip select, serial clock and serial data out are low. `req_ready` is high, and `rsp_rvalid`, `rsp_done` and `rsp_err` are low.
- R2: Each frame is sent MSB first, in this order: a start bit of 1, a 2-bit device opcode, a 10-bit address field and, for writes only, 16 data bits. The opcodes are read = 10, write = 01 and write-all = 00. For write-all the address field is 01 followed by eight zeros. Serial data out changes only while the serial clock falls or is low, and it never changes on a rising edge.
- R3: The serial clock toggles only while chip select is high. Its first rise comes `DIV` system cycles after chip select rises, and its period is `2*DIV` system cycles.
- R4: For a read, the level sampled at the 14th rising edge is the dummy bit and is discarded. The next 16 rising edges build the data word MSB first. The word is presented on `rsp_rdata` with a one-cycle `rsp_rvalid`.
- R5: A burst read of `req_len` words keeps chip select high for the whole burst. It yields one word per 16 further clocks from consecutive addresses, giving exactly `req_len` `rsp_rvalid` pulses. A `req_len` of 0 counts as 1. The request op codes are 0 = read, 1 = burst read, 2 = write and 3 = write-all.
- R6: A write or write-all frame has exactly 29 rising edges. Chip select falls `DIV` system cycles after the 29th rise, together with the clock's fall, and no 30th rise is issued.
- R7: After a write, chip select is raised again with no clock. The device output is read each cycle, where 0 means busy and 1 means ready. On ready, chip select drops and a done pulse with no error follows. No new frame starts while the device is busy.
- R8: If ready is not seen within `TIMEOUT_CYC` system cycles of polling, polling stops and the done pulse carries `rsp_err` = 1. A ready level seen in the same cycle as timeout expiry wins, and no error is flagged.
- R9: Between any two selections, chip select stays low for at least `GAP_CYC` system cycles. `req_ready` is low from acceptance until the done pulse.
- R10: `rsp_done` is a single-cycle pulse, one per request, and `rsp_err` is high only together with `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_op | input | 2 | Operation: 0 read, 1 burst read, 2 write, 3 write-all |
| req_addr | input | AW (10) | Word address |
| req_wdata | input | DW (16) | Data for write and write-all |
| req_len | input | LW (8) | Word count for a burst read (0 counts as 1) |
| rsp_rdata | output | DW (16) | Last word read |
| rsp_rvalid | output | 1 | One-cycle strobe for `rsp_rdata` |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Ready timeout, valid with `rsp_done` |
| mw_cs | output | 1 | Chip select to the memory |
| mw_sck | output | 1 | Serial clock to the memory |
| mw_di | output | 1 | Serial data toward the memory |
| mw_do | input | 1 | Serial data and ready/busy level from the memory |

## Verification
While polling, the ready level and the expiry of the timeout counter can land in the same system cycle. The controller must then treat the write as complete rather than failed. The bench provokes this by repeating a write while stepping the memory model's busy time, two cycles at a time, across the timeout boundary. For each run it compares `rsp_err` with whether the model ever showed ready while it was still selected, so the error flag must be set exactly when the device never reported ready.

// File: rtl/mwh_pkg.sv
package mwh_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_BURST = 2'd1,
    OP_WRITE = 2'd2,
    OP_WRALL = 2'd3
  } mwh_op_e;

  localparam logic [1:0] DEV_RD    = 2'b10;
  localparam logic [1:0] DEV_WR    = 2'b01;
  localparam logic [1:0] DEV_EXT   = 2'b00;
  localparam logic [1:0] EXT_WRALL = 2'b01;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SHIFT,
    S_ENDF,
    S_GAP,
    S_POLL
  } mwh_state_e;
endpackage

// File: rtl/mwh_sck_gen.sv
module mwh_sck_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = $clog2(DIV + 1);

  logic [CW-1:0] cnt;
  logic          phase;
  logic          hit;

  assign hit = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (hit) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign rise_tick = hit && !phase;
  assign fall_tick = hit && phase;
endmodule

// File: rtl/mwh_cycle_timer.sv
module mwh_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt < limit) cnt <= cnt + W'(1);
  end

  assign hit = (cnt >= limit);
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mwh_pkg::*;
#(
  parameter int DIV         = 4,
  parameter int AW          = 10,
  parameter int DW          = 16,
  parameter int LW          = 8,
  parameter int GAP_CYC     = 4,
  parameter int TIMEOUT_CYC = 200000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [LW-1:0] req_len,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_rvalid,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic          mw_cs,
  output logic          mw_sck,
  output logic          mw_di,
  input  logic          mw_do
);
  localparam int HDR  = 3 + AW;
  localparam int FL   = HDR + DW;
  localparam int CW   = $clog2(FL + 1);
  localparam int WBW  = $clog2(DW);
  localparam int TMAX = (TIMEOUT_CYC > GAP_CYC) ? TIMEOUT_CYC : GAP_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  mwh_state_e    state;
  logic [FL-1:0] frame, sr;
  logic [CW-1:0] rises;
  logic [WBW-1:0] wbit;
  logic [DW-1:0] rx;
  logic [LW-1:0] words;
  logic          is_wr, polled, err_pend, tmr_clr;
  logic          rise_tick, fall_tick, tmr_hit, tmr_done;
  logic [TW-1:0] tmr_lim;

  mwh_sck_gen #(.DIV(DIV)) u_sck (
    .clk       (clk),
    .rst       (rst),
    .en        ((state == S_SHIFT) || (state == S_ENDF)),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  assign tmr_lim = (state == S_POLL) ? TW'(TIMEOUT_CYC - 1) : TW'(GAP_CYC - 1);

  mwh_cycle_timer #(.W(TW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .limit (tmr_lim),
    .hit   (tmr_hit)
  );

  assign tmr_done  = tmr_hit && !tmr_clr;
  assign req_ready = (state == S_IDLE);

  always_comb begin
    case (req_op)
      OP_WRITE: frame = {1'b1, DEV_WR, req_addr, req_wdata};
      OP_WRALL: frame = {1'b1, DEV_EXT, EXT_WRALL, {(AW-2){1'b0}}, req_wdata};
      default:  frame = {1'b1, DEV_RD, req_addr, {DW{1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      mw_cs      <= 1'b0;
      mw_sck     <= 1'b0;
      mw_di      <= 1'b0;
      sr         <= '0;
      rises      <= '0;
      wbit       <= '0;
      rx         <= '0;
      words      <= '0;
      is_wr      <= 1'b0;
      polled     <= 1'b0;
      err_pend   <= 1'b0;
      tmr_clr    <= 1'b1;
      rsp_rdata  <= '0;
      rsp_rvalid <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_err    <= 1'b0;
    end else begin
      rsp_rvalid <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_err    <= 1'b0;
      tmr_clr    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            mw_cs    <= 1'b1;
            mw_di    <= frame[FL-1];
            sr       <= {frame[FL-2:0], 1'b0};
            rises    <= '0;
            wbit     <= '0;
            is_wr    <= req_op[1];
            polled   <= 1'b0;
            err_pend <= 1'b0;
            if (req_op == OP_BURST && req_len != '0) words <= req_len;
            else words <= LW'(1);
            state    <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (fall_tick) begin
            mw_sck <= 1'b0;
            mw_di  <= sr[FL-1];
            sr     <= {sr[FL-2:0], 1'b0};
          end
          if (rise_tick) begin
            mw_sck <= 1'b1;
            if (rises != CW'(FL)) rises <= rises + CW'(1);
            if (is_wr) begin
              if (rises == CW'(FL - 1)) state <= S_ENDF;
            end else if (rises >= CW'(HDR + 1)) begin
              rx <= {rx[DW-2:0], mw_do};
              if (wbit == WBW'(DW - 1)) begin
                wbit       <= '0;
                rsp_rdata  <= {rx[DW-2:0], mw_do};
                rsp_rvalid <= 1'b1;
                words      <= words - LW'(1);
                if (words == LW'(1)) state <= S_ENDF;
              end else begin
                wbit <= wbit + WBW'(1);
              end
            end
          end
        end
        S_ENDF: begin
          if (fall_tick) begin
            mw_sck  <= 1'b0;
            mw_cs   <= 1'b0;
            mw_di   <= 1'b0;
            tmr_clr <= 1'b1;
            state   <= S_GAP;
          end
        end
        S_GAP: begin
          if (tmr_done) begin
            if (is_wr && !polled) begin
              mw_cs   <= 1'b1;
              tmr_clr <= 1'b1;
              state   <= S_POLL;
            end else begin
              rsp_done <= 1'b1;
              rsp_err  <= err_pend;
              state    <= S_IDLE;
            end
          end
        end
        S_POLL: begin
          if (mw_do || tmr_done) begin
            err_pend <= !mw_do;
            mw_cs    <= 1'b0;
            polled   <= 1'b1;
            tmr_clr  <= 1'b1;
            state    <= S_GAP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwh_checker.sv
module mwh_checker #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic       rsp_rvalid,
  input logic       rsp_done,
  input logic       rsp_err,
  input logic       mw_cs,
  input logic       mw_sck,
  input logic       mw_di
);
  localparam int FL = 3 + AW + DW;
  localparam int RW = $clog2(FL + 2);

  logic          sck_q, cs_q, wr_q;
  logic [RW-1:0] rc;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
      wr_q  <= 1'b0;
      rc    <= '0;
    end else begin
      sck_q <= mw_sck;
      cs_q  <= mw_cs;
      if (req_valid && req_ready) wr_q <= req_op[1];
      if (mw_cs && !cs_q) rc <= '0;
      else if (mw_sck && !sck_q && rc != RW'(FL + 1)) rc <= rc + RW'(1);
    end
  end

  AST_SCK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !mw_cs |-> !mw_sck); // R3
  AST_DI_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(mw_sck) |-> $stable(mw_di)); // R2
  AST_READY_ONLY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mw_cs); // R9
  AST_CS_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!mw_cs && cs_q) |=> !mw_cs); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_done); // R8
  AST_RVALID_SELECTED: assert property (@(posedge clk) disable iff (rst)
    rsp_rvalid |-> mw_cs); // R4
  AST_WR_FRAME_29: assert property (@(posedge clk) disable iff (rst)
    (!mw_cs && cs_q && wr_q && rc != '0) |-> (rc == RW'(FL))); // R6
endmodule

bind mw_eeprom_host mwh_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .rsp_rvalid (rsp_rvalid),
  .rsp_done   (rsp_done),
  .rsp_err    (rsp_err),
  .mw_cs      (mw_cs),
  .mw_sck     (mw_sck),
  .mw_di      (mw_di)
);

// File: tb/mw_eeprom_host_bench.sv
`timescale 1ns/1ps
module mw_eeprom_host_bench;
  localparam int DIV = 3, AW = 10, DW = 16, LW = 8, GAP = 4, TMO = 1500;
  localparam real TCK = 20.0;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [LW-1:0] req_len = '0;
  logic [DW-1:0] rsp_rdata;
  logic rsp_rvalid, rsp_done, rsp_err, mw_cs, mw_sck, mw_di, mw_do;

  always #(TCK/2) clk = ~clk;

  mw_eeprom_host #(.DIV(DIV), .AW(AW), .DW(DW), .LW(LW), .GAP_CYC(GAP), .TIMEOUT_CYC(TMO))
    u_mw_eeprom_host (.*);

  int checks = 0, fails = 0;

  // ---------------- memory device model ----------------
  logic [15:0] mem [0:1023];
  bit started, busy, do_reg, ready_shown, first_rise;
  int n, rbit, busy_cnt, busy_len = 200, commits, viol, period_err, poll_len, cs_rises, last_n;
  logic [1:0] m_op;
  logic [9:0] m_addr, raddr;
  logic [15:0] m_data;
  realtime t_rise, t_csrise, t_csfall, min_gap = 1.0e9, fall_delay;

  assign mw_do = !mw_cs ? 1'b0 : (!started ? !busy : do_reg);

  always @(posedge mw_cs) begin
    started = 0; n = 0; ready_shown = 0; poll_len = 0; first_rise = 1; cs_rises++;
    t_csrise = $realtime;
    if ($realtime - t_csfall < min_gap) min_gap = $realtime - t_csfall;
  end

  always @(posedge mw_sck) if (mw_cs) begin
    if (first_rise) begin
      if ($realtime - t_csrise != DIV*TCK) period_err++;
    end else if ($realtime - t_rise != 2*DIV*TCK) period_err++;
    first_rise = 0;
    t_rise = $realtime;
    if (!started) begin
      if (mw_di) begin started = 1; n = 0; if (busy) viol++; end
    end else begin
      n++;
      if (n <= 2) m_op = {m_op[0], mw_di};
      else if (n <= 12) m_addr = {m_addr[8:0], mw_di};
      else if (n <= 28) m_data = {m_data[14:0], mw_di};
      if (m_op == 2'b10 && n == 12) begin
        do_reg = 1'b0; raddr = m_addr; rbit = 0;
      end else if (m_op == 2'b10 && n > 12) begin
        do_reg = mem[raddr][15-rbit];
        if (rbit == 15) begin rbit = 0; raddr = raddr + 10'd1; end
        else rbit++;
      end
    end
  end

  always @(negedge mw_cs) begin
    t_csfall = $realtime;
    if (started) begin
      last_n = n;
      fall_delay = $realtime - t_rise;
      if (n == 28 && m_op == 2'b01) begin
        mem[m_addr] = m_data; busy = 1; busy_cnt = busy_len; commits++;
      end else if (n == 28 && m_op == 2'b00 && m_addr[9:8] == 2'b01) begin
        for (int i = 0; i < 1024; i++) mem[i] = m_data;
        busy = 1; busy_cnt = busy_len; commits++;
      end
    end
    started = 0;
  end

  always @(negedge clk) begin
    if (busy) begin
      if (busy_cnt <= 1) busy = 0; else busy_cnt--;
    end
    if (mw_cs && !started) begin
      poll_len++;
      if (!busy) ready_shown = 1;
    end
  end

  // ---------------- helpers ----------------
  logic [15:0] rd_words [0:15];
  int n_rd;
  bit r_err;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] op, input logic [9:0] addr,
                         input logic [15:0] wd, input logic [7:0] len);
    bit got;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = addr; req_wdata = wd; req_len = len;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R9", "req_ready after accept", req_ready, 0);
    n_rd = 0; got = 0; r_err = 0;
    for (int k = 0; k < 20000; k++) begin
      if (rsp_rvalid && n_rd < 16) begin rd_words[n_rd] = rsp_rdata; n_rd++; end
      if (rsp_done) begin got = 1; r_err = rsp_err; break; end
      @(negedge clk);
    end
    chk(got, "R10", "done seen", got, 1);
    @(negedge clk);
    chk(!rsp_done, "R10", "done single cycle", rsp_done, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(!mw_cs && !mw_sck && !mw_di, "R1", "pins low", {mw_cs, mw_sck, mw_di}, 0);
    chk(req_ready, "R1", "req_ready", req_ready, 1);
    chk(!rsp_rvalid && !rsp_done && !rsp_err, "R1", "response idle",
        {rsp_rvalid, rsp_done, rsp_err}, 0);
  endtask

  task automatic t_write();
    int c0 = commits;
    busy_len = 200;
    run_req(2'd2, 10'h2A5, 16'h1234, 8'd0);
    chk(m_op == 2'b01, "R2", "write opcode", m_op, 1);
    chk(m_addr == 10'h2A5, "R2", "write address", m_addr, 'h2A5);
    chk(m_data == 16'h1234, "R2", "write data", m_data, 'h1234);
    chk(last_n == 28, "R6", "bits after start", last_n, 28);
    chk(int'(fall_delay) == int'(DIV*TCK), "R6", "cs fall delay ns", int'(fall_delay), int'(DIV*TCK));
    chk(commits == c0 + 1 && mem[10'h2A5] == 16'h1234, "R6", "write committed", mem[10'h2A5], 'h1234);
    chk(!r_err && !busy && ready_shown, "R7", "done after ready", {r_err, busy}, 0);
    chk(poll_len > 100, "R7", "poll waited through busy", poll_len, 101);
  endtask

  task automatic t_read();
    run_req(2'd0, 10'h2A5, 16'h0, 8'd0);
    chk(m_op == 2'b10, "R2", "read opcode", m_op, 2);
    chk(n_rd == 1, "R4", "word count", n_rd, 1);
    chk(rd_words[0] == 16'h1234, "R4", "read word", rd_words[0], 'h1234);
  endtask

  task automatic t_burst();
    int c0;
    mem[10'h3FE] = 16'hA001; mem[10'h3FF] = 16'hB002; mem[10'h000] = 16'hC003;
    c0 = cs_rises;
    run_req(2'd1, 10'h3FE, 16'h0, 8'd3);
    chk(cs_rises == c0 + 1, "R5", "single selection", cs_rises - c0, 1);
    chk(n_rd == 3, "R5", "burst word count", n_rd, 3);
    chk(rd_words[0] == 16'hA001 && rd_words[1] == 16'hB002 && rd_words[2] == 16'hC003,
        "R5", "burst words", rd_words[2], 'hC003);
    mem[10'h155] = 16'h7E81;
    run_req(2'd1, 10'h155, 16'h0, 8'd0);
    chk(n_rd == 1 && rd_words[0] == 16'h7E81, "R5", "length zero gives one word", n_rd, 1);
  endtask

  task automatic t_wral();
    busy_len = 60;
    run_req(2'd3, 10'h0, 16'h5AC3, 8'd0);
    chk(m_op == 2'b00 && m_addr == 10'h100, "R2", "write-all header", {m_op, m_addr}, 'h100);
    chk(last_n == 28, "R6", "write-all bits", last_n, 28);
    chk(mem[0] == 16'h5AC3 && mem[10'h1FF] == 16'h5AC3 && mem[10'h3FF] == 16'h5AC3,
        "R6", "all words written", mem[10'h3FF], 'h5AC3);
    chk(!r_err, "R7", "write-all no error", r_err, 0);
  endtask

  task automatic t_timeout();
    busy_len = 5000;
    run_req(2'd2, 10'h011, 16'hBEEF, 8'd0);
    chk(r_err, "R8", "timeout error", r_err, 1);
    chk(busy && !ready_shown, "R8", "device still busy", busy, 1);
    wait (!busy);
  endtask

  task automatic t_boundary();
    int errs = 0;
    for (int b = TMO - 6; b <= TMO + 14; b += 2) begin
      busy_len = b;
      run_req(2'd2, 10'(b), 16'(b), 8'd0);
      chk(r_err == !ready_shown, "R8", "err versus ready seen", r_err, !ready_shown);
      if (r_err) begin
        errs++;
        chk(poll_len >= TMO - 1, "R8", "poll length before error", poll_len, TMO);
      end
      wait (!busy);
    end
    chk(errs > 0 && errs < 11, "R8", "sweep crossed boundary", errs, 5);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_burst();
    t_wral();
    t_timeout();
    t_boundary();
    chk(period_err == 0, "R3", "clock timing errors", period_err, 0);
    chk(int'(min_gap) >= GAP*int'(TCK), "R9", "minimum cs low ns", int'(min_gap), GAP*int'(TCK));
    chk(viol == 0, "R7", "commands while busy", viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10: actual no completion expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule